// File: doc/BRIEF.md
# Codec power-down and status controller

This block is the digital control core behind the power-down and status configuration of a stereo audio codec. It keeps one 8-bit configuration byte, written through a plain write strobe and read back at all times. Three power bits (reference, ADC path, DAC path) decide whether the ADC sample stream carries data, whether the DAC analog output is driven, and whether the input gain and output attenuation codes sit at zero or move toward their programmed values.

When the ADC path comes up (also after reset), the sample stream carries zeros for a fixed count of frame strobes before real samples pass. The input gain and output attenuation codes fade in by one step per frame strobe. A single status pin reports either an ADC overflow or a DAC zero condition, with a polarity inversion and a force-low disable. ADC samples pass through as a valid/ready stream: back-pressure from the sink reaches the source combinationally (`s_ready` equals `m_ready`), `m_valid` follows `s_valid`, and no sample is buffered. A word transfers on a cycle where both valid and ready are high. Powering the ADC down changes only the data, never the handshake.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset `cfg_q` reads 0x07. Bit 7 is slow filter select, bit 6 is status invert, bit 5 is status disable, bit 4 is status source select, bit 3 is reserved, bit 2 is reference on, bit 1 is ADC on and bit 0 is DAC on. Bit 3 always reads 0 whatever is written.
- R2: A write (`wr_en` high at a clock edge) updates `cfg_q` from the next cycle on in every power state. Power changes never alter the stored byte.
- R3: The DAC path is enabled only when bits 2 and 0 are both 1. `dac_oe` is low in the same cycle that `cfg_q` shows the DAC path disabled.
- R4: While the ADC path is disabled (bit 2 or bit 1 is 0), `m_data` is 0 and `gain_cur` is 0 in the same cycle that `cfg_q` shows it.
- R5: Bit 2 at 0 disables both paths regardless of bits 1 and 0.
- R6: After reset and after each enable of the ADC path, `m_data` is 0 until MUTE_FRAMES (516) `lrck_tick` pulses have been seen with the path enabled. Samples pass from the cycle after the last of them. Disabling the path during the window restarts the count.
- R7: While the ADC path is enabled, each `lrck_tick` moves `gain_cur` one step toward `gain_set`, up or down. A new `gain_set` is followed from the current value.
- R8: `att_cur` behaves the same way with `att_set` under the DAC path enable: it is 0 while the DAC path is disabled and fades in after it is enabled.
- R9: With bit 4 at 0 the status source is the OR of `adc_ovf`. With bit 4 at 1 the source is the AND of `dac_zero`.
- R10: With bit 6 at 0 `status_pin` equals the source. With bit 6 at 1 it is the inverse of the source.
- R11: With bit 5 at 1 `status_pin` is 0.
- R12: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` at all times. Once enabled and past the window, `m_data` equals `s_data`.
- R13: `slow_filt` equals bit 7 of `cfg_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write byte |
| cfg_q | output | 8 | Configuration readback |
| lrck_tick | input | 1 | One-cycle pulse per audio frame |
| s_valid | input | 1 | ADC sample valid |
| s_ready | output | 1 | ADC sample ready (back-pressure) |
| s_data | input | SW | ADC sample in |
| m_valid | output | 1 | Gated sample valid |
| m_ready | input | 1 | Sink ready |
| m_data | output | SW | Gated sample out |
| adc_ovf | input | CH | Per-channel ADC overflow flags |
| dac_zero | input | CH | Per-channel DAC zero flags |
| gain_set | input | GW | Programmed input gain code |
| gain_cur | output | GW | Applied input gain code |
| att_set | input | GW | Programmed output attenuation code |
| att_cur | output | GW | Applied output attenuation code |
| dac_oe | output | 1 | DAC analog output drive enable |
| status_pin | output | 1 | Multiplexed status output |
| slow_filt | output | 1 | Slow roll-off filter select |

## Verification
A frame counter that is off by one shows at `m_data` exactly on the 516th strobe: either zeros for one frame too many, or a real sample one frame early. A counter that fails to restart shows up as samples passing too soon after a short power-down. A fade register stuck or stepping wrongly diverges from the expected code on the first strobe after power-up, or on the first strobe after a new target. Power-gating and status errors are combinational and appear in the same cycle as the configuration change, so random configuration bytes paired with random flag patterns expose them at once.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef struct packed {
    logic slow;
    logic inv;
    logic stat_off;
    logic stat_sel;
    logic rsvd;
    logic ref_on;
    logic adc_on;
    logic dac_on;
  } cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h07;
  localparam logic [7:0] CFG_WMASK = 8'hF7;
endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import codec_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output cfg_t       cfg
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_en) cfg_q <= wr_data & CFG_WMASK;
  end

  assign cfg = cfg_t'(cfg_q);
endmodule

// File: rtl/adc_mute_gate.sv
module adc_mute_gate #(
  parameter int SW          = 24,
  parameter int MUTE_FRAMES = 516,
  localparam int CW         = $clog2(MUTE_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [SW-1:0] s_data,
  output logic [SW-1:0] m_data
);
  localparam logic [CW-1:0] LOAD = CW'(MUTE_FRAMES);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= LOAD;
    else if (!en) remain <= LOAD;
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  assign m_data = (en && remain == '0) ? s_data : '0;
endmodule

// File: rtl/fade_ramp.sv
module fade_ramp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic [W-1:0] level
);
  logic [W-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (!en) cur <= '0;
    else if (tick) begin
      if (cur < target) cur <= cur + 1'b1;
      else if (cur > target) cur <= cur - 1'b1;
    end
  end

  assign level = en ? cur : '0;
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux #(
  parameter int CH = 2
) (
  input  logic          sel_zero,
  input  logic          invert,
  input  logic          force_low,
  input  logic [CH-1:0] ovf,
  input  logic [CH-1:0] zero,
  output logic          pin
);
  logic src;

  always_comb begin
    src = sel_zero ? (&zero) : (|ovf);
    pin = force_low ? 1'b0 : (src ^ invert);
  end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int SW          = 24,
  parameter int GW          = 8,
  parameter int CH          = 2,
  parameter int MUTE_FRAMES = 516
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    cfg_q,
  input  logic          lrck_tick,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [SW-1:0] m_data,
  input  logic [CH-1:0] adc_ovf,
  input  logic [CH-1:0] dac_zero,
  input  logic [GW-1:0] gain_set,
  output logic [GW-1:0] gain_cur,
  input  logic [GW-1:0] att_set,
  output logic [GW-1:0] att_cur,
  output logic          dac_oe,
  output logic          status_pin,
  output logic          slow_filt
);
  localparam int NPATH = 2;

  cfg_t cfg;
  logic adc_en, dac_en;
  logic [NPATH-1:0]         path_en;
  logic [NPATH-1:0][GW-1:0] path_tgt;
  logic [NPATH-1:0][GW-1:0] path_lvl;

  pwr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg)
  );

  assign adc_en = cfg.ref_on & cfg.adc_on;
  assign dac_en = cfg.ref_on & cfg.dac_on;

  adc_mute_gate #(.SW(SW), .MUTE_FRAMES(MUTE_FRAMES)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(adc_en), .tick(lrck_tick),
    .s_data(s_data), .m_data(m_data)
  );

  assign path_en  = {dac_en, adc_en};
  assign path_tgt = {att_set, gain_set};

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_fade
    fade_ramp #(.W(GW)) u_fade (
      .clk(clk), .rst_n(rst_n), .en(path_en[gi]), .tick(lrck_tick),
      .target(path_tgt[gi]), .level(path_lvl[gi])
    );
  end

  status_pin_mux #(.CH(CH)) u_stat (
    .sel_zero(cfg.stat_sel), .invert(cfg.inv), .force_low(cfg.stat_off),
    .ovf(adc_ovf), .zero(dac_zero), .pin(status_pin)
  );

  assign gain_cur  = path_lvl[0];
  assign att_cur   = path_lvl[1];
  assign cfg_q     = cfg;
  assign dac_oe    = dac_en;
  assign slow_filt = cfg.slow;
  assign m_valid   = s_valid;
  assign s_ready   = m_ready;
endmodule

// File: rtl/codec_pwr_ctrl_chk.sv
module codec_pwr_ctrl_chk #(
  parameter int SW = 24,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    cfg_q,
  input logic          dac_oe,
  input logic [SW-1:0] m_data,
  input logic [GW-1:0] gain_cur,
  input logic [GW-1:0] att_cur,
  input logic          status_pin,
  input logic          slow_filt
);
  logic adc_on_w, dac_on_w;
  assign adc_on_w = cfg_q[2] & cfg_q[1];
  assign dac_on_w = cfg_q[2] & cfg_q[0];

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[3] == 1'b0);

  p_dac_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_on_w |-> (!dac_oe && att_cur == '0));

  p_adc_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_on_w |-> (m_data == '0 && gain_cur == '0));

  p_ref_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[2] |-> (!dac_oe && m_data == '0));

  p_gain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_on_w && $past(adc_on_w)) |->
      (gain_cur == $past(gain_cur) || gain_cur == $past(gain_cur) + GW'(1)
       || gain_cur == $past(gain_cur) - GW'(1)));

  p_stat_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[5] |-> !status_pin);

  p_slow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    slow_filt == cfg_q[7]);
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk #(.SW(SW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .dac_oe(dac_oe), .m_data(m_data),
  .gain_cur(gain_cur), .att_cur(att_cur), .status_pin(status_pin),
  .slow_filt(slow_filt)
);

// File: tb/codec_pwr_ctrl_test.sv
module codec_pwr_ctrl_test;
  localparam int SW = 24, GW = 8, CH = 2, MF = 516;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, lrck_tick = 0, s_valid = 0, m_ready = 0;
  logic [7:0] wr_data = 0;
  logic [SW-1:0] s_data = 0;
  logic [CH-1:0] adc_ovf = 0, dac_zero = 0;
  logic [GW-1:0] gain_set = 0, att_set = 0;
  logic [7:0] cfg_q;
  logic s_ready, m_valid, dac_oe, status_pin, slow_filt;
  logic [SW-1:0] m_data;
  logic [GW-1:0] gain_cur, att_cur;

  int checks = 0, fails = 0, cyc = 0;

  codec_pwr_ctrl #(.SW(SW), .GW(GW), .CH(CH), .MUTE_FRAMES(MF)) uut (.*);

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      lrck_tick = 1;
      @(posedge clk); #1;
      lrck_tick = 0;
    end
    @(negedge clk);
  endtask

  function automatic logic stat_exp(input logic [7:0] c, input logic [CH-1:0] o,
                                    input logic [CH-1:0] z);
    logic src;
    src = c[4] ? (&z) : (|o);
    return c[5] ? 1'b0 : (src ^ c[6]);
  endfunction

  task automatic sample_pass(input string tag);
    s_data = SW'($urandom) | 24'h1;
    #1;
    chk(m_data == s_data, tag, m_data, s_data);
  endtask

  task automatic sample_zero(input string tag);
    s_data = SW'($urandom) | 24'h1;
    #1;
    chk(m_data == '0, tag, m_data, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    gain_set = 8'd5; att_set = 8'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_q == 8'h07, "R1 reset cfg", cfg_q, 8'h07);
    chk(dac_oe == 1'b1, "R3 dac_oe after reset", dac_oe, 1);
    chk(gain_cur == 0, "R7 gain at reset", gain_cur, 0);
    sample_zero("R6 window after reset");
    // R7 fade up
    ticks(3);
    chk(gain_cur == 3, "R7 gain after 3 ticks", gain_cur, 3);
    chk(att_cur == 3, "R8 att after 3 ticks", att_cur, 3);
    ticks(MF - 4);
    sample_zero("R6 window at 515 ticks");
    ticks(1);
    sample_pass("R6 window over at 516 ticks");
    chk(gain_cur == 5, "R7 gain reached target", gain_cur, 5);
    // R12 stream
    for (int i = 0; i < 20; i++) begin
      s_valid = 1'($urandom); m_ready = 1'($urandom);
      sample_pass("R12 data pass");
      chk(m_valid == s_valid, "R12 valid follows", m_valid, s_valid);
      chk(s_ready == m_ready, "R12 ready follows", s_ready, m_ready);
    end
    // R7 fade down, retarget
    gain_set = 8'd2;
    ticks(1);
    chk(gain_cur == 4, "R7 gain down one step", gain_cur, 4);
    ticks(5);
    chk(gain_cur == 2, "R7 gain settles at new target", gain_cur, 2);
    // R3/R8 DAC down
    wr(8'h06);
    chk(dac_oe == 0, "R3 dac off", dac_oe, 0);
    chk(att_cur == 0, "R8 att zero when dac off", att_cur, 0);
    chk(cfg_q == 8'h06, "R2 readback", cfg_q, 8'h06);
    sample_pass("R3 adc unaffected by dac off");
    wr(8'h07);
    chk(att_cur == 0, "R8 att starts at zero", att_cur, 0);
    ticks(1);
    chk(att_cur == 1, "R8 att fades in", att_cur, 1);
    // R1 reserved bit
    wr(8'h0F);
    chk(cfg_q == 8'h07, "R1 reserved bit reads 0", cfg_q, 8'h07);
    // R4 ADC down
    wr(8'h05);
    sample_zero("R4 adc off data");
    chk(gain_cur == 0, "R4 adc off gain", gain_cur, 0);
    chk(dac_oe == 1, "R4 dac stays on", dac_oe, 1);
    wr(8'h07);
    ticks(300);
    wr(8'h05);
    chk(cfg_q == 8'h05, "R2 write while adc off", cfg_q, 8'h05);
    wr(8'h07);
    ticks(MF - 1);
    sample_zero("R6 restart 515 ticks");
    ticks(1);
    sample_pass("R6 restart complete");
    chk(gain_cur == 2, "R7 gain refaded", gain_cur, 2);
    // R9-R11, R13 random status
    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      c = (8'($urandom) & 8'hF0) | 8'h07;
      wr(c);
      for (int k = 0; k < 4; k++) begin
        adc_ovf = CH'($urandom); dac_zero = CH'($urandom);
        #1;
        if (c[5]) chk(status_pin == 0, "R11 disable", status_pin, 0);
        else if (c[6]) chk(status_pin == stat_exp(c, adc_ovf, dac_zero), "R10 invert", status_pin, stat_exp(c, adc_ovf, dac_zero));
        else chk(status_pin == stat_exp(c, adc_ovf, dac_zero), "R9 source", status_pin, stat_exp(c, adc_ovf, dac_zero));
      end
      chk(slow_filt == c[7], "R13 slow bit", slow_filt, c[7]);
    end
    // R5 reference down
    wr(8'h03);
    chk(dac_oe == 0, "R5 ref off dac", dac_oe, 0);
    sample_zero("R5 ref off adc");
    chk(cfg_q == 8'h03, "R2 bits kept", cfg_q, 8'h03);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule